// File: doc/BRIEF.md
# Programmable Down-Counter Timer with Interrupt

This block is one 32-bit timer channel reached through an APB slave port. Software programs a reload value and a control word. While enabled, the counter drops by one on every clock. When it gets to zero, one of two things happens. In free-running mode it wraps to all ones. In periodic mode it reloads the programmed value. In both modes a raw interrupt flag is recorded. The interrupt output is that flag gated by a mask bit. Software acknowledges the interrupt by reading a clear register, and the read itself is the acknowledge.

The register file has two parts. The channel part holds the reload value, the live count, the control word, the clear register and the status. A shared part holds masked status, a global clear, raw status and a fixed version word. The convention for changing the count is to disable the timer, write the reload value, and enable it again. The new value is taken on the clock edge after enable rises.

Top module: `apb_down_timer`

## Requirements
- R1: After reset the control word, reload value, count and raw flag are zero, irq_o is low, and reads of 0x00, 0x04, 0x08, 0x10 and 0xA8 return zero.
- R2: Offset 0x00 holds the 32-bit reload value (read/write). Offset 0x08 holds the control word in bits [2:0], where bit 0 is enable, bit 1 selects periodic (1) or free-running (0), and bit 2 is the interrupt mask; its upper bits read zero. 0xAC returns the VERSION parameter, and any unmapped offset reads zero.
- R3: On the clock edge after the enable bit goes from 0 to 1, the count takes the reload value.
- R4: While enabled, the count decreases by one per clock, and a read of 0x04 returns the count as it stands at that access.
- R5: While disabled, the count holds its value. Writing the reload value while disabled leaves the count untouched until the next enable.
- R6: In free-running mode, an enabled count of zero becomes 0xFFFFFFFF on the next edge.
- R7: In periodic mode, an enabled count of zero takes the reload value on the next edge.
- R8: The raw flag sets on the edge at which an enabled count leaves zero, which is reload value + 2 edges after the enabling write. irq_o equals the raw flag with the mask clear. 0x10 and 0xA0 return the masked flag in bit 0, and 0xA8 returns the raw flag in bit 0.
- R9: A read of 0x0C or 0xA4 returns zero and clears the raw flag. A write to either offset has no effect.
- R10: Writes to 0x04, 0x0C, 0x10, 0xA0, 0xA4, 0xA8 and 0xAC are ignored. pready_o is always high and pslverr_o is always low.
- R11: With the mask set, irq_o stays low while the raw flag still records the event. Clearing the mask then drives irq_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB access phase |
| pwrite_i | input | 1 | APB write, 1 = write |
| paddr_i | input | ADDR_W | APB byte address |
| pwdata_i | input | DATA_W | APB write data |
| prdata_o | output | DATA_W | APB read data |
| pready_o | output | 1 | APB ready, tied high |
| pslverr_o | output | 1 | APB error, tied low |
| irq_o | output | 1 | Level interrupt, active high |

## Verification
A wrong count shows at the current-value register on the next read and at the interrupt timing. Because the interrupt edge is checked to the exact cycle, a load or decrement fault moves irq_o by at least one clock. A flag that fails to set or fails to clear shows on irq_o and on the raw status within one edge of the cause. A fault in the mask or mode decode shows as a wrong value after wrap, either all ones or the reload value, within reload + 2 edges of enabling.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam logic [7:0] OFF_LOAD  = 8'h00;
  localparam logic [7:0] OFF_CUR   = 8'h04;
  localparam logic [7:0] OFF_CTRL  = 8'h08;
  localparam logic [7:0] OFF_CLR   = 8'h0C;
  localparam logic [7:0] OFF_STAT  = 8'h10;
  localparam logic [7:0] OFF_GSTAT = 8'hA0;
  localparam logic [7:0] OFF_GCLR  = 8'hA4;
  localparam logic [7:0] OFF_RAW   = 8'hA8;
  localparam logic [7:0] OFF_VER   = 8'hAC;

  typedef struct packed {
    logic mask;
    logic periodic;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/timer_regs.sv
module timer_regs
  import timer_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 8,
  parameter logic [DATA_W-1:0] VERSION = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic              raw_i,
  output ctrl_t             ctrl_o,
  output logic [DATA_W-1:0] load_o,
  output logic              clr_rd_o,
  output logic [DATA_W-1:0] prdata_o
);
  localparam int unsigned CtrlW = $bits(ctrl_t);

  logic access, wr, rd, masked;
  assign access = psel_i & penable_i;
  assign wr     = access & pwrite_i;
  assign rd     = access & ~pwrite_i;
  assign masked = raw_i & ~ctrl_o.mask;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] off);
    return a == ADDR_W'(off);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
      load_o <= '0;
    end else if (wr) begin
      if (hit(paddr_i, OFF_LOAD)) load_o <= pwdata_i;
      if (hit(paddr_i, OFF_CTRL)) ctrl_o <= ctrl_t'(pwdata_i[CtrlW-1:0]);
    end
  end

  assign clr_rd_o = rd & (hit(paddr_i, OFF_CLR) | hit(paddr_i, OFF_GCLR));

  always_comb begin
    prdata_o = '0;
    if      (hit(paddr_i, OFF_LOAD))  prdata_o = load_o;
    else if (hit(paddr_i, OFF_CUR))   prdata_o = cnt_i;
    else if (hit(paddr_i, OFF_CTRL))  prdata_o = DATA_W'(ctrl_o);
    else if (hit(paddr_i, OFF_STAT) || hit(paddr_i, OFF_GSTAT)) prdata_o = DATA_W'(masked);
    else if (hit(paddr_i, OFF_RAW))   prdata_o = DATA_W'(raw_i);
    else if (hit(paddr_i, OFF_VER))   prdata_o = VERSION;
  end
endmodule

// File: rtl/timer_counter.sv
module timer_counter
  import timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctrl_t             ctrl_i,
  input  logic [DATA_W-1:0] load_i,
  input  logic              clr_rd_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic              en_q_o,
  output logic              raw_o
);
  logic en_rise, at_zero, fire;
  assign en_rise = ctrl_i.en & ~en_q_o;
  assign at_zero = cnt_o == '0;
  assign fire    = ctrl_i.en & ~en_rise & at_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o  <= '0;
      en_q_o <= 1'b0;
      raw_o  <= 1'b0;
    end else begin
      en_q_o <= ctrl_i.en;
      if (en_rise)       cnt_o <= load_i;
      else if (fire)     cnt_o <= ctrl_i.periodic ? load_i : '1;
      else if (ctrl_i.en) cnt_o <= cnt_o - 1'b1;
      // set takes priority over a clear in the same cycle
      raw_o <= fire | (raw_o & ~clr_rd_i);
    end
  end
endmodule

// File: rtl/apb_down_timer.sv
module apb_down_timer
  import timer_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 8,
  parameter logic [DATA_W-1:0] VERSION = 32'h0001_0200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  output logic              pready_o,
  output logic              pslverr_o,
  output logic              irq_o
);
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] load_q, cnt_q;
  logic              clr_rd, raw_q, en_q;

  timer_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .VERSION(VERSION)) i_regs (
    .clk_i, .rst_ni, .psel_i, .penable_i, .pwrite_i, .paddr_i, .pwdata_i,
    .cnt_i(cnt_q), .raw_i(raw_q), .ctrl_o(ctrl_q), .load_o(load_q),
    .clr_rd_o(clr_rd), .prdata_o
  );

  timer_counter #(.DATA_W(DATA_W)) i_cnt (
    .clk_i, .rst_ni, .ctrl_i(ctrl_q), .load_i(load_q), .clr_rd_i(clr_rd),
    .cnt_o(cnt_q), .en_q_o(en_q), .raw_o(raw_q)
  );

  assign irq_o     = raw_q & ~ctrl_q.mask;
  assign pready_o  = 1'b1;
  assign pslverr_o = 1'b0;
endmodule

// File: rtl/timer_chk.sv
module timer_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en,
  input logic              periodic,
  input logic              mask,
  input logic              en_q,
  input logic [DATA_W-1:0] load_q,
  input logic [DATA_W-1:0] cnt_q,
  input logic              raw_q,
  input logic              clr_rd,
  input logic              irq_o
);
  p_rise_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !en_q) |=> cnt_q == $past(load_q));
  p_decrement_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && en_q && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> $stable(cnt_q));
  p_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && en_q && cnt_q == '0 && !periodic) |=> &cnt_q);
  p_reload_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && en_q && cnt_q == '0 && periodic) |=> cnt_q == $past(load_q));
  p_raw_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(raw_q) |-> $past(en && en_q && cnt_q == '0));
  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_rd && !(en && en_q && cnt_q == '0)) |=> !raw_q);
  p_mask_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask |-> !irq_o);
endmodule

bind apb_down_timer timer_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en(ctrl_q.en), .periodic(ctrl_q.periodic),
  .mask(ctrl_q.mask), .en_q(en_q), .load_q(load_q), .cnt_q(cnt_q),
  .raw_q(raw_q), .clr_rd(clr_rd), .irq_o(irq_o)
);

// File: tb/test_apb_down_timer.sv
`timescale 1ns/1ps
module test_apb_down_timer;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 8;
  localparam logic [DW-1:0] VER = 32'h0001_0200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] pwdata = '0, prdata;
  logic pready, pslverr, irq;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  apb_down_timer #(.DATA_W(DW), .ADDR_W(AW), .VERSION(VER)) i_apb_down_timer (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .pready_o(pready), .pslverr_o(pslverr), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [7:0] a, input logic [DW-1:0] d);
    psel = 1'b1; pwrite = 1'b1; paddr = AW'(a); pwdata = d;
    @(posedge clk); @(negedge clk); penable = 1'b1;
    @(posedge clk); @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [DW-1:0] d);
    psel = 1'b1; pwrite = 1'b0; paddr = AW'(a);
    @(posedge clk); @(negedge clk); penable = 1'b1;
    #0.5 d = prdata;
    @(posedge clk); @(negedge clk); psel = 1'b0; penable = 1'b0;
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    chk("R1 irq", DW'(irq), 0);
    chk("R10 pready", DW'(pready), 1);
    chk("R10 pslverr", DW'(pslverr), 0);
    rd(8'h00, v); chk("R1 load", v, 0);
    rd(8'h04, v); chk("R1 count", v, 0);
    rd(8'h08, v); chk("R1 ctrl", v, 0);
    rd(8'h10, v); chk("R1 status", v, 0);
    rd(8'hA8, v); chk("R1 raw", v, 0);
  endtask

  task automatic t_regmap();
    logic [DW-1:0] v;
    wr(8'h00, 32'hDEAD_BEEF); rd(8'h00, v); chk("R2 load rw", v, 32'hDEAD_BEEF);
    wr(8'h08, 32'hFFFF_FFF6); rd(8'h08, v); chk("R2 ctrl bits", v, 32'h6);
    wr(8'h08, 0);
    rd(8'hAC, v); chk("R2 version", v, VER);
    wr(8'hAC, 32'h1234_5678); rd(8'hAC, v); chk("R10 version ro", v, VER);
    rd(8'h20, v); chk("R2 unmapped", v, 0);
  endtask

  task automatic t_count();
    logic [DW-1:0] a, b;
    wr(8'h08, 0); wr(8'h00, 20); wr(8'h08, 1);
    rd(8'h04, a); chk("R3 load on enable", a, 20);
    rd(8'h04, a); chk("R4 decrement", a, 18);
    wr(8'h08, 0);
    rd(8'h04, a); rd(8'h04, b); chk("R5 hold", b, a);
    wr(8'h00, 7); rd(8'h04, b); chk("R5 load while disabled", b, a);
    wr(8'h04, 32'h1234); rd(8'h04, b); chk("R10 current ro", b, a);
    wr(8'h08, 1); rd(8'h04, b); chk("R3 new load", b, 7);
    wr(8'h08, 0);
  endtask

  task automatic t_wrap();
    logic [DW-1:0] v;
    rd(8'h0C, v);
    wr(8'h00, 3); wr(8'h08, 1);
    rd(8'h04, v); chk("R3 load 3", v, 3);
    rd(8'h04, v); chk("R4 count 1", v, 1);
    rd(8'h04, v); chk("R6 wrap", v, 32'hFFFF_FFFF);
    chk("R8 irq after wrap", DW'(irq), 1);
    rd(8'hA8, v); chk("R8 raw", v, 1);
    rd(8'h10, v); chk("R8 status", v, 1);
    rd(8'hA0, v); chk("R8 global status", v, 1);
    wr(8'h0C, 0); chk("R9 write no clear", DW'(irq), 1);
    rd(8'h0C, v); chk("R9 clear data", v, 0);
    chk("R9 clear by read", DW'(irq), 0);
    wr(8'h08, 0);
  endtask

  task automatic t_timing();
    logic [DW-1:0] v;
    int n = 0;
    wr(8'h00, 4); wr(8'h08, 1);
    while (n < 6) begin
      @(posedge clk); @(negedge clk); n++;
      if (n == 5) chk("R8 irq not early", DW'(irq), 0);
    end
    chk("R8 irq at load+2", DW'(irq), 1);
    rd(8'hA4, v); chk("R9 global clear data", v, 0);
    chk("R9 global clear", DW'(irq), 0);
    wr(8'h08, 0);
  endtask

  task automatic t_periodic();
    logic [DW-1:0] v;
    wr(8'h00, 3); wr(8'h08, 3);
    rd(8'h04, v); chk("R3 periodic load", v, 3);
    rd(8'h04, v); chk("R4 periodic count", v, 1);
    rd(8'h04, v); chk("R7 reload", v, 3);
    rd(8'h04, v); chk("R7 after reload", v, 1);
    wr(8'h08, 0); rd(8'h0C, v);
  endtask

  task automatic t_mask();
    logic [DW-1:0] v;
    wr(8'h00, 2); wr(8'h08, 5);
    repeat (8) begin @(posedge clk); @(negedge clk); end
    chk("R11 masked irq", DW'(irq), 0);
    rd(8'hA8, v); chk("R11 raw kept", v, 1);
    rd(8'h10, v); chk("R11 masked status", v, 0);
    rd(8'hA0, v); chk("R11 masked global", v, 0);
    wr(8'h08, 1); chk("R11 unmask", DW'(irq), 1);
    rd(8'h0C, v); chk("R9 clear after unmask", DW'(irq), 0);
    wr(8'h08, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_count();
    t_wrap();
    t_timing();
    t_periodic();
    t_mask();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule